// File: doc/BRIEF.md
# Deferred Miss Slice Controller

This block sits beside the issue stage of an in-order pipeline that keeps running when a load misses in the data cache or in a lower cache level. Every instruction passes through it with its source and destination register numbers, the values of its sources as read from the register file, and a miss flag plus a miss tag. The block decides in the same cycle whether the instruction executes normally or is poisoned and deferred. Deferred instructions are queued in program order together with any source values that were already valid. Each register carries a pending bit and a mask of the outstanding miss tags it waits on.

When a miss comes back, the block walks the queued entries once. An entry whose tag mask has become zero is sent out for replay. An entry that still waits on another miss goes back to the tail, so later passes handle fewer entries. Independent tail instructions keep issuing while a pass runs. The block also raises a checkpoint pulse when the first miss arrives, and a release pulse once the queue is empty and no miss is outstanding.

Mode encoding on `mode`: 0 is normal, 1 is advance, 2 is rally (a replay pass is running).

Top module: `slice_defer_ctl`

## Requirements
- R1: An accepted miss while in normal mode (mode 0) pulses `ckpt_take` in that cycle, and mode reads 1 in the next cycle. A miss accepted while already in advance does not pulse `ckpt_take`.
- R2: An accepted instruction whose enabled sources are not pending gives `ex_go`=1 and `ex_defer`=0 in its cycle. It also clears the pending state of its destination.
- R3: An accepted instruction with `in_miss`=1, or with an enabled source that is pending, gives `ex_defer`=1 and is queued. Its destination becomes pending, so later readers of that register are deferred as well.
- R4: A queued entry captures each enabled source that was not pending: on replay, `rp_opN_cap`=1 and `rp_opN` holds the captured value. A source that was pending or disabled replays with cap=0 and value 0.
- R5: A miss return at cycle T starts a pass in cycle T+2. The pass presents one queued entry per cycle in program order, and `mode` reads 2 while the pass runs.
- R6: During a pass, an entry that still waits on an outstanding tag is put back at the tail without replay. A later return replays it.
- R7: With 32 entries queued, an instruction that would be deferred sees `in_ready`=0 and is not accepted. An instruction that would not be deferred is still accepted.
- R8: During a pass (and from the return cycle until the pass starts), independent instructions are accepted and executed. Instructions that would be deferred see `in_ready`=0.
- R9: When the queue is empty and no tag is outstanding in advance mode, `ckpt_release` pulses and mode returns to 0 in the next cycle. After the last replay of a pass at cycle X, the pulse comes in cycle X+1.
- R10: Each accepted instruction takes the next sequence number (`ex_seq`, starting at 0 after reset). A replay asserts `rp_wr_ok` only if no younger instruction has written the same destination.
- R11: A return of tag t clears only bit t of the wait masks. Entries that also wait on another outstanding tag are not replayed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_s0_en | input | 1 | Source 0 is used |
| in_s0_idx | input | 4 | Source 0 register number |
| in_s0_val | input | 16 | Source 0 value read from the register file |
| in_s1_en | input | 1 | Source 1 is used |
| in_s1_idx | input | 4 | Source 1 register number |
| in_s1_val | input | 16 | Source 1 value read from the register file |
| in_dst_we | input | 1 | Instruction writes a register |
| in_dst_idx | input | 4 | Destination register number |
| in_miss | input | 1 | Instruction is a load that missed |
| in_miss_tag | input | 2 | Tag of that miss |
| ret_valid | input | 1 | A miss has returned |
| ret_tag | input | 2 | Tag of the returned miss |
| ex_go | output | 1 | Accepted instruction executes normally |
| ex_defer | output | 1 | Accepted instruction is poisoned and queued |
| ex_seq | output | 8 | Sequence number of the offered instruction |
| ckpt_take | output | 1 | Take a register checkpoint |
| ckpt_release | output | 1 | Discard the checkpoint |
| mode | output | 2 | 0 normal, 1 advance, 2 rally |
| rp_valid | output | 1 | A queued entry is replayed this cycle |
| rp_seq | output | 8 | Sequence number of the replayed entry |
| rp_dst_we | output | 1 | Replayed entry writes a register |
| rp_dst_idx | output | 4 | Destination of the replayed entry |
| rp_wr_ok | output | 1 | Replay result may update the register |
| rp_op0_cap | output | 1 | Source 0 value was captured |
| rp_op0 | output | 16 | Captured source 0 value |
| rp_op1_cap | output | 1 | Source 1 value was captured |
| rp_op1 | output | 16 | Captured source 1 value |

## Verification
The issue decision (`ex_go`, `ex_defer`, `in_ready`, `ckpt_take`, `ex_seq`) is combinational, so the bench checks it in the same cycle the instruction is driven. It samples one time unit after the falling edge. Replays are due two cycles after the return and then follow one per cycle. A scoreboard queue holds the expected entries in program order, and a monitor compares every `rp_valid` cycle against the queue head. The release pulse is checked for the exact cycle count after the return: four cycles for a two-entry pass, thirty-four for a full queue. The mode change is checked one cycle later.

// File: rtl/slc_pkg.sv
package slc_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_ADVANCE = 2'd1,
        MODE_RALLY   = 2'd2
    } mode_e;

endpackage

// File: rtl/slc_poison_tab.sv
module slc_poison_tab #(
    parameter int NREG = 16,
    parameter int NTAG = 4,
    parameter int SEQW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rd_a_idx,
    output logic                    rd_a_pend,
    output logic [NTAG-1:0]         rd_a_mask,
    input  logic [$clog2(NREG)-1:0] rd_b_idx,
    output logic                    rd_b_pend,
    output logic [NTAG-1:0]         rd_b_mask,
    input  logic [$clog2(NREG)-1:0] own_idx,
    input  logic [SEQW-1:0]         own_seq,
    output logic                    own_match,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic                    wr_pend,
    input  logic [NTAG-1:0]         wr_mask,
    input  logic [SEQW-1:0]         wr_seq,
    input  logic                    clr_en,
    input  logic [$clog2(NREG)-1:0] clr_idx,
    input  logic                    ret_en,
    input  logic [$clog2(NTAG)-1:0] ret_tag
);

    typedef struct packed {
        logic [NREG-1:0]                pend;
        logic [NREG-1:0][NTAG-1:0]      mask;
        logic [NREG-1:0][SEQW-1:0]      owner;
    } tab_t;

    tab_t tab_q, tab_d;

    always_comb begin
        tab_d = tab_q;
        if (ret_en) begin
            for (int r = 0; r < NREG; r++) begin
                tab_d.mask[r][ret_tag] = 1'b0;
            end
        end
        if (clr_en) begin
            tab_d.pend[clr_idx] = 1'b0;
        end
        if (wr_en) begin
            tab_d.pend[wr_idx]  = wr_pend;
            tab_d.mask[wr_idx]  = wr_mask;
            tab_d.owner[wr_idx] = wr_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign rd_a_pend = tab_q.pend[rd_a_idx];
    assign rd_a_mask = tab_q.mask[rd_a_idx];
    assign rd_b_pend = tab_q.pend[rd_b_idx];
    assign rd_b_mask = tab_q.mask[rd_b_idx];
    assign own_match = (tab_q.owner[own_idx] == own_seq);

    // a register cleared by a replay stays non-pending unless rewritten
    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(wr_en && wr_idx == clr_idx)) |=> !tab_q.pend[$past(clr_idx)]); // R10

endmodule

// File: rtl/slc_queue.sv
module slc_queue #(
    parameter int DEPTH = 32,
    parameter int EW    = 40,
    parameter int NTAG  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [EW-1:0]              push_data,
    input  logic [NTAG-1:0]            push_mask,
    input  logic                       pop,
    output logic [EW-1:0]              head_data,
    output logic [NTAG-1:0]            head_mask,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty,
    input  logic                       ret_en,
    input  logic [$clog2(NTAG)-1:0]    ret_tag
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0]   data;
        logic [DEPTH-1:0][NTAG-1:0] mask;
        logic [AW-1:0]              head;
        logic [AW-1:0]              tail;
        logic [CW-1:0]              cnt;
    } q_t;

    q_t q_q, q_d;
    logic [NTAG-1:0] pm;

    always_comb begin
        q_d = q_q;
        pm  = push_mask;
        if (ret_en) begin
            pm[ret_tag] = 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                q_d.mask[i][ret_tag] = 1'b0;
            end
        end
        if (push) begin
            q_d.data[q_q.tail] = push_data;
            q_d.mask[q_q.tail] = pm;
            q_d.tail = (q_q.tail == AW'(DEPTH-1)) ? '0 : q_q.tail + AW'(1);
        end
        if (pop) begin
            q_d.head = (q_q.head == AW'(DEPTH-1)) ? '0 : q_q.head + AW'(1);
        end
        q_d.cnt = q_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head_data = q_q.data[q_q.head];
    assign head_mask = q_q.mask[q_q.head];
    assign count     = q_q.cnt;
    assign full      = (q_q.cnt == CW'(DEPTH));
    assign empty     = (q_q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> !full); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R5

endmodule

// File: rtl/slc_rally_ctl.sv
module slc_rally_ctl
    import slc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int NTAG  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       new_miss,
    input  logic [$clog2(NTAG)-1:0]    new_tag,
    input  logic                       ret_en,
    input  logic [$clog2(NTAG)-1:0]    ret_tag,
    input  logic [$clog2(DEPTH+1)-1:0] q_count,
    output logic                       pass_active,
    output logic                       pass_hold,
    output logic                       ckpt_take,
    output logic                       ckpt_release,
    output mode_e                      mode
);

    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic            adv;
        logic            pend_pass;
        logic [CW-1:0]   left;
        logic [NTAG-1:0] outst;
    } ctl_t;

    ctl_t c_q, c_d;
    logic start;

    always_comb begin
        c_d          = c_q;
        pass_active  = (c_q.left != '0);
        pass_hold    = c_q.pend_pass;
        start        = !pass_active && c_q.pend_pass;
        ckpt_take    = new_miss && !c_q.adv;
        ckpt_release = c_q.adv && (q_count == '0) && (c_q.outst == '0) &&
                       !pass_active && !c_q.pend_pass && !new_miss;

        if (new_miss) c_d.outst[new_tag] = 1'b1;
        if (ret_en)   c_d.outst[ret_tag] = 1'b0;

        if (ret_en)     c_d.pend_pass = 1'b1;
        else if (start) c_d.pend_pass = 1'b0;

        if (start)            c_d.left = q_count;
        else if (pass_active) c_d.left = c_q.left - CW'(1);

        if (ckpt_take)         c_d.adv = 1'b1;
        else if (ckpt_release) c_d.adv = 1'b0;

        if (pass_active)   mode = MODE_RALLY;
        else if (c_q.adv)  mode = MODE_ADVANCE;
        else               mode = MODE_NORMAL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    AST_CKPT_ENTERS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_take |=> (mode != MODE_NORMAL)); // R1
    AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_release |-> (q_count == '0 && c_q.outst == '0)); // R9
    AST_RELEASE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_release |=> (mode == MODE_NORMAL)); // R9

endmodule

// File: rtl/slice_defer_ctl.sv
module slice_defer_ctl
    import slc_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int NTAG  = 4,
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    parameter int SEQW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_s0_en,
    input  logic [$clog2(NREG)-1:0] in_s0_idx,
    input  logic [DW-1:0]           in_s0_val,
    input  logic                    in_s1_en,
    input  logic [$clog2(NREG)-1:0] in_s1_idx,
    input  logic [DW-1:0]           in_s1_val,
    input  logic                    in_dst_we,
    input  logic [$clog2(NREG)-1:0] in_dst_idx,
    input  logic                    in_miss,
    input  logic [$clog2(NTAG)-1:0] in_miss_tag,
    input  logic                    ret_valid,
    input  logic [$clog2(NTAG)-1:0] ret_tag,
    output logic                    ex_go,
    output logic                    ex_defer,
    output logic [SEQW-1:0]         ex_seq,
    output logic                    ckpt_take,
    output logic                    ckpt_release,
    output logic [1:0]              mode,
    output logic                    rp_valid,
    output logic [SEQW-1:0]         rp_seq,
    output logic                    rp_dst_we,
    output logic [$clog2(NREG)-1:0] rp_dst_idx,
    output logic                    rp_wr_ok,
    output logic                    rp_op0_cap,
    output logic [DW-1:0]           rp_op0,
    output logic                    rp_op1_cap,
    output logic [DW-1:0]           rp_op1
);

    localparam int RW = $clog2(NREG);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [SEQW-1:0] seq;
        logic            dst_we;
        logic [RW-1:0]   dst;
        logic            c0;
        logic [DW-1:0]   op0;
        logic            c1;
        logic [DW-1:0]   op1;
    } entry_t;

    localparam int EW = $bits(entry_t);

    typedef struct packed {
        logic [SEQW-1:0] seq;
    } top_t;

    top_t t_q, t_d;

    logic            a_pend, b_pend, own_match;
    logic [NTAG-1:0] a_mask, b_mask;
    logic            s0p, s1p, poison, accept, block;
    logic [NTAG-1:0] new_mask, miss_bit, head_mask, push_mask;
    entry_t          new_ent, head_ent;
    logic [EW-1:0]   head_raw, push_data;
    logic            push, pop, redefer, q_full, q_empty;
    logic [CW-1:0]   q_count;
    logic            pass_active, pass_hold, new_miss;
    logic            tab_wr, clr_en;
    mode_e           mode_w;

    always_comb begin
        t_d      = t_q;
        s0p      = in_s0_en && a_pend;
        s1p      = in_s1_en && b_pend;
        poison   = s0p || s1p || in_miss;
        block    = q_full || pass_active || pass_hold || ret_valid;
        in_ready = !(poison && block);
        accept   = in_valid && in_ready;
        ex_go    = accept && !poison;
        ex_defer = accept && poison;
        ex_seq   = t_q.seq;
        new_miss = accept && in_miss;

        miss_bit = '0;
        miss_bit[in_miss_tag] = in_miss;
        new_mask = (s0p ? a_mask : '0) | (s1p ? b_mask : '0) | miss_bit;

        new_ent.seq    = t_q.seq;
        new_ent.dst_we = in_dst_we;
        new_ent.dst    = in_dst_idx;
        new_ent.c0     = in_s0_en && !a_pend;
        new_ent.op0    = (in_s0_en && !a_pend) ? in_s0_val : '0;
        new_ent.c1     = in_s1_en && !b_pend;
        new_ent.op1    = (in_s1_en && !b_pend) ? in_s1_val : '0;

        head_ent  = entry_t'(head_raw);
        pop       = pass_active;
        rp_valid  = pass_active && (head_mask == '0);
        redefer   = pass_active && (head_mask != '0);
        push      = ex_defer || redefer;
        push_data = ex_defer ? EW'(new_ent) : head_raw;
        push_mask = ex_defer ? new_mask : head_mask;

        tab_wr    = accept && in_dst_we;
        rp_wr_ok  = rp_valid && head_ent.dst_we && own_match &&
                    !(tab_wr && in_dst_idx == head_ent.dst);
        clr_en    = rp_wr_ok;

        rp_seq     = head_ent.seq;
        rp_dst_we  = head_ent.dst_we;
        rp_dst_idx = head_ent.dst;
        rp_op0_cap = head_ent.c0;
        rp_op0     = head_ent.op0;
        rp_op1_cap = head_ent.c1;
        rp_op1     = head_ent.op1;

        t_d.seq = t_q.seq + SEQW'(accept);
        mode    = mode_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    slc_poison_tab #(.NREG(NREG), .NTAG(NTAG), .SEQW(SEQW)) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (in_s0_idx),
        .rd_a_pend (a_pend),
        .rd_a_mask (a_mask),
        .rd_b_idx  (in_s1_idx),
        .rd_b_pend (b_pend),
        .rd_b_mask (b_mask),
        .own_idx   (head_ent.dst),
        .own_seq   (head_ent.seq),
        .own_match (own_match),
        .wr_en     (tab_wr),
        .wr_idx    (in_dst_idx),
        .wr_pend   (poison),
        .wr_mask   (poison ? new_mask : '0),
        .wr_seq    (t_q.seq),
        .clr_en    (clr_en),
        .clr_idx   (head_ent.dst),
        .ret_en    (ret_valid),
        .ret_tag   (ret_tag)
    );

    slc_queue #(.DEPTH(DEPTH), .EW(EW), .NTAG(NTAG)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .push_mask (push_mask),
        .pop       (pop),
        .head_data (head_raw),
        .head_mask (head_mask),
        .count     (q_count),
        .full      (q_full),
        .empty     (q_empty),
        .ret_en    (ret_valid),
        .ret_tag   (ret_tag)
    );

    slc_rally_ctl #(.DEPTH(DEPTH), .NTAG(NTAG)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .new_miss     (new_miss),
        .new_tag      (in_miss_tag),
        .ret_en       (ret_valid),
        .ret_tag      (ret_tag),
        .q_count      (q_count),
        .pass_active  (pass_active),
        .pass_hold    (pass_hold),
        .ckpt_take    (ckpt_take),
        .ckpt_release (ckpt_release),
        .mode         (mode_w)
    );

    AST_RALLY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        rp_valid |-> (mode == 2'd2)); // R5
    AST_NO_TAIL_DEFER_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        pass_active |-> !ex_defer); // R8
    AST_REDEFER_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        redefer |=> (q_count == $past(q_count))); // R6
    AST_REPLAY_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rp_valid |-> !q_empty); // R5

endmodule

// File: tb/slice_defer_ctl_tb.sv
module slice_defer_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic        in_s0_en = 1'b0, in_s1_en = 1'b0;
    logic [3:0]  in_s0_idx = '0, in_s1_idx = '0, in_dst_idx = '0;
    logic [15:0] in_s0_val = '0, in_s1_val = '0;
    logic        in_dst_we = 1'b0, in_miss = 1'b0;
    logic [1:0]  in_miss_tag = '0;
    logic        ret_valid = 1'b0;
    logic [1:0]  ret_tag = '0;
    logic        ex_go, ex_defer, ckpt_take, ckpt_release;
    logic [7:0]  ex_seq, rp_seq;
    logic [1:0]  mode;
    logic        rp_valid, rp_dst_we, rp_wr_ok, rp_op0_cap, rp_op1_cap;
    logic [3:0]  rp_dst_idx;
    logic [15:0] rp_op0, rp_op1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int seq; int dst; bit wr_ok; bit c0; int op0; bit c1; int op1;
    } rp_t;
    rp_t exp_q[$];

    always #5 clk = ~clk;

    slice_defer_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_s0_en(in_s0_en), .in_s0_idx(in_s0_idx), .in_s0_val(in_s0_val),
        .in_s1_en(in_s1_en), .in_s1_idx(in_s1_idx), .in_s1_val(in_s1_val),
        .in_dst_we(in_dst_we), .in_dst_idx(in_dst_idx), .in_miss(in_miss),
        .in_miss_tag(in_miss_tag), .ret_valid(ret_valid), .ret_tag(ret_tag),
        .ex_go(ex_go), .ex_defer(ex_defer), .ex_seq(ex_seq),
        .ckpt_take(ckpt_take), .ckpt_release(ckpt_release), .mode(mode),
        .rp_valid(rp_valid), .rp_seq(rp_seq), .rp_dst_we(rp_dst_we),
        .rp_dst_idx(rp_dst_idx), .rp_wr_ok(rp_wr_ok), .rp_op0_cap(rp_op0_cap),
        .rp_op0(rp_op0), .rp_op1_cap(rp_op1_cap), .rp_op1(rp_op1)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_rp(input int seq, input int dst, input bit wr_ok,
                             input bit c0, input int op0, input bit c1, input int op1);
        rp_t e;
        e.seq = seq; e.dst = dst; e.wr_ok = wr_ok;
        e.c0 = c0; e.op0 = op0; e.c1 = c1; e.op1 = op1;
        exp_q.push_back(e);
    endtask

    // monitor: compares each replay with the head of the expected queue
    always @(negedge clk) begin
        #3;
        if (rst_n && rp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected replay seq", int'(rp_seq), -1);
            end else begin
                rp_t e;
                e = exp_q.pop_front();
                chk(int'(rp_seq) == e.seq && int'(rp_dst_idx) == e.dst,
                    "R5", "replay order seq", int'(rp_seq), e.seq);
                chk(rp_wr_ok == e.wr_ok, "R10", "replay wr_ok", int'(rp_wr_ok), int'(e.wr_ok));
                chk(rp_op0_cap == e.c0 && int'(rp_op0) == e.op0 &&
                    rp_op1_cap == e.c1 && int'(rp_op1) == e.op1,
                    "R4", "captured op0/op1", int'({rp_op0_cap, rp_op0, rp_op1_cap, rp_op1}),
                    int'({e.c0, 16'(e.op0), e.c1, 16'(e.op1)}));
            end
        end
    end

    // driver: called just after a falling edge, returns at the next one
    task automatic issue(input bit s0e, input int s0i, input int s0v,
                         input bit s1e, input int s1i, input int s1v,
                         input bit dwe, input int di, input bit miss, input int tag,
                         output bit rdy, output bit go, output bit df,
                         output bit ck, output int sq);
        in_valid = 1'b1;
        in_s0_en = s0e; in_s0_idx = 4'(s0i); in_s0_val = 16'(s0v);
        in_s1_en = s1e; in_s1_idx = 4'(s1i); in_s1_val = 16'(s1v);
        in_dst_we = dwe; in_dst_idx = 4'(di);
        in_miss = miss; in_miss_tag = 2'(tag);
        #1;
        rdy = in_ready; go = ex_go; df = ex_defer; ck = ckpt_take; sq = int'(ex_seq);
        @(negedge clk);
        in_valid = 1'b0; in_miss = 1'b0; in_s0_en = 1'b0; in_s1_en = 1'b0; in_dst_we = 1'b0;
    endtask

    task automatic miss_return(input int tag);
        ret_valid = 1'b1; ret_tag = 2'(tag);
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    // polls for the release pulse, returns cycles waited since call
    task automatic wait_release(input int limit, output int cyc);
        cyc = -1;
        for (int i = 0; i < limit; i++) begin
            #1;
            if (ckpt_release) begin
                cyc = i;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit rdy, go, df, ck;
        int sq, cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(mode == 2'd0, "R1", "reset mode", int'(mode), 0);
        chk(in_ready && !ex_go && !ex_defer && !rp_valid && !ckpt_take, "R1",
            "reset outputs quiet", int'({in_ready, ex_go, ex_defer, rp_valid, ckpt_take}), 16);
        @(negedge clk);

        // independent instruction in normal mode
        issue(1, 3, 'h33, 0, 0, 0, 1, 3, 0, 0, rdy, go, df, ck, sq);
        chk(go && !df, "R2", "normal exec", int'({go, df}), 2);
        chk(sq == 0, "R10", "first seq", sq, 0);

        // first miss: checkpoint + advance
        issue(0, 0, 0, 0, 0, 0, 1, 1, 1, 0, rdy, go, df, ck, sq);
        chk(df && ck, "R1", "miss defers and checkpoints", int'({df, ck}), 3);
        #1;
        chk(mode == 2'd1, "R1", "advance after miss", int'(mode), 1);
        expect_rp(1, 1, 1, 0, 0, 0, 0);

        // reader of r1 with captured r3
        issue(1, 1, 'h11, 1, 3, 'h33, 1, 2, 0, 0, rdy, go, df, ck, sq);
        chk(df && !go && sq == 2, "R3", "dependent deferred", int'({go, df}), 1);
        expect_rp(2, 2, 0, 0, 0, 1, 'h33);

        // independent in advance
        issue(1, 5, 'h55, 0, 0, 0, 1, 4, 0, 0, rdy, go, df, ck, sq);
        chk(go && !df, "R2", "advance independent exec", int'({go, df}), 2);

        // second miss, tag 1: no new checkpoint
        issue(0, 0, 0, 0, 0, 0, 1, 6, 1, 1, rdy, go, df, ck, sq);
        chk(df && !ck, "R1", "second miss no checkpoint", int'({df, ck}), 2);
        issue(1, 6, 0, 0, 0, 0, 1, 7, 0, 0, rdy, go, df, ck, sq);
        chk(df, "R3", "reader of tag1 load deferred", int'(df), 1);

        // younger writer of r2 commits
        issue(1, 5, 'h55, 0, 0, 0, 1, 2, 0, 0, rdy, go, df, ck, sq);
        chk(go && sq == 6, "R10", "younger r2 writer seq", sq, 6);

        // return tag 0: pass over 4 entries, interleave tail work
        miss_return(0);
        #1;
        chk(mode == 2'd1, "R5", "no pass in T+1", int'(mode), 1);
        @(negedge clk);
        #1;
        chk(mode == 2'd2, "R5", "rally in T+2", int'(mode), 2);
        issue(1, 5, 'h55, 0, 0, 0, 1, 8, 0, 0, rdy, go, df, ck, sq);
        chk(rdy && go && sq == 7, "R8", "tail exec during pass", int'({rdy, go}), 3);
        issue(1, 7, 0, 0, 0, 0, 1, 9, 0, 0, rdy, go, df, ck, sq);
        chk(!rdy && !df, "R8", "poisoned tail held during pass", int'({rdy, df}), 0);
        repeat (3) @(negedge clk);
        #1;
        chk(mode == 2'd1, "R6", "back to advance with tag1 waiting", int'(mode), 1);
        chk(exp_q.size() == 0, "R11", "tag0 replays done, tag1 kept", exp_q.size(), 0);
        @(negedge clk);

        // return tag 1: re-deferred entries replay, then release
        expect_rp(4, 6, 1, 0, 0, 0, 0);
        expect_rp(5, 7, 1, 0, 0, 0, 0);
        miss_return(1);
        wait_release(20, cyc);
        chk(cyc == 3, "R9", "release cycle after return", cyc, 3);
        #1;
        chk(mode == 2'd0, "R9", "normal after release", int'(mode), 0);
        chk(exp_q.size() == 0, "R6", "re-deferred entries replayed", exp_q.size(), 0);
        @(negedge clk);

        // fill the queue
        issue(0, 0, 0, 0, 0, 0, 1, 1, 1, 2, rdy, go, df, ck, sq);
        chk(df && ck && sq == 8, "R1", "checkpoint on new miss", int'({df, ck}), 3);
        expect_rp(8, 1, 1, 0, 0, 0, 0);
        for (int k = 0; k < 31; k++) begin
            issue(1, 1, 0, 1, 3, k + 100, 1, 10, 0, 0, rdy, go, df, ck, sq);
            chk(df && sq == 9 + k, "R3", "fill entry deferred", sq, 9 + k);
            expect_rp(9 + k, 10, (k == 30), 0, 0, 1, k + 100);
        end
        issue(1, 1, 0, 0, 0, 0, 1, 11, 0, 0, rdy, go, df, ck, sq);
        chk(!rdy && !df, "R7", "full blocks poisoned", int'({rdy, df}), 0);
        issue(1, 5, 'h55, 0, 0, 0, 1, 12, 0, 0, rdy, go, df, ck, sq);
        chk(rdy && go && sq == 40, "R7", "full accepts independent", int'({rdy, go}), 3);

        miss_return(2);
        wait_release(80, cyc);
        chk(cyc == 33, "R9", "release after full pass", cyc, 33);
        #1;
        chk(mode == 2'd0, "R9", "normal after full pass", int'(mode), 0);
        chk(exp_q.size() == 0, "R5", "all 32 replayed", exp_q.size(), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule